// File: doc/BRIEF.md
# Descriptor Ring DMA Engine

This block moves 32-bit words from a local FIFO data port into system memory. It follows a ring of descriptors that it reads from memory. Software places a ring of 16-byte descriptors in memory and starts the engine with one control write. The engine then fetches each descriptor and copies the descriptor's byte count from the FIFO to consecutive destination addresses. It then follows the next pointer. The ring closes on itself, so the engine runs until it is aborted.

Each descriptor has four words at offsets 0, 4, 8 and 12, read in that order: the destination address, the fixed local source address, the byte count, and the next pointer. Bits [3:0] of the next-pointer word hold flags. Bit 2 asks for an interrupt when that descriptor completes. Bit 0 marks a descriptor held in system memory and bit 3 gives the transfer direction (local to system). The engine carries bits 0 and 3 but does not act on them. A word moves only while the source reports data ready. The current destination address is always visible, so software can tell how far the ring has advanced.

Top module: `ring_dma_engine`

## Requirements
- R1: A control write with `ctl_enable`, `ctl_start` and `ctl_irq_clr` all 1, made while idle with `ctl_ptr[3:0]==0`, sets `busy` at the next clock edge and starts fetching at `ctl_ptr`. After reset `busy`, `irq`, `mem_req` and `src_pop` are 0.
- R2: A start is refused, with no bus request and `busy` staying 0, if any of bits [3:0] of `ctl_ptr` is set or if any of the three control bits is 0.
- R3: A descriptor fetch is four single-word reads (`mem_we`=0) at base+0, +4, +8 and +12, in that order. No data write for that descriptor is issued before the fourth read completes.
- R4: The byte count in use is the field value capped at 65536 and then rounded down to a multiple of 4. If the result is zero, the engine goes idle after the fetch without writing.
- R5: A FIFO word is popped (`src_pop`) only in a cycle with `src_ready`=1. Each popped word is written, in pop order, to `cur_dst`, which then advances by 4.
- R6: While a descriptor is transferring, `src_addr` equals that descriptor's source field and is never incremented.
- R7: Once raised, `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until the cycle in which `mem_ack` is 1.
- R8: After the last word of a descriptor, the next fetch starts at the next-pointer word with bits [3:0] cleared. A ring that points back to its first descriptor runs without end.
- R9: After the final write of a descriptor whose next-pointer bit 2 is set, `irq` is 1 from the next cycle on and stays 1 until it is cleared. With bit 2 clear, no interrupt is raised.
- R10: Any control write with `ctl_irq_clr`=1 clears `irq` and leaves `busy` and the transfer unchanged. If the clear and a descriptor completion fall in the same cycle, the completion wins.
- R11: An `abort` pulse stops the engine at the next word boundary. A bus transaction already pending completes, no new request follows, and `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_enable | input | 1 | Control enable bit |
| ctl_start | input | 1 | Control start bit |
| ctl_irq_clr | input | 1 | Control interrupt-clear bit |
| ctl_ptr | input | 32 | First descriptor address for a start |
| abort | input | 1 | Stop at the next word boundary |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Completes the pending request |
| src_ready | input | 1 | FIFO has a word |
| src_data | input | 32 | FIFO head word |
| src_pop | output | 1 | Takes the FIFO head word |
| src_addr | output | 32 | Fixed local source address of the descriptor |
| cur_dst | output | 32 | Next destination address |
| busy | output | 1 | Engine not idle |
| irq | output | 1 | Sticky descriptor-complete interrupt |

## Verification
The bench drives a ring whose next pointers carry set flag bits. A design that failed to mask them would fetch from a misaligned address on the second lap. It makes the memory acknowledge late and withholds FIFO data in a fixed pattern, which catches a request that drops or changes before its acknowledge, and catches a pop taken without data. A descriptor larger than 64 KiB must stop after exactly 16384 writes, and a descriptor with a count of 3 must go idle without writing. An engine that got either wrong would write the wrong number of words or hang in its fetch. An abort must leave at most one further transaction, an interrupt clear issued in mid-run must leave the engine busy, and a misaligned or incomplete start must produce no bus activity.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_FETCH    = 2'd1,
    ST_WAIT_SRC = 2'd2,
    ST_WRITE    = 2'd3
  } dma_state_t;

  // Field positions inside a descriptor (word index)
  localparam int unsigned FLD_DST  = 0;
  localparam int unsigned FLD_SRC  = 1;
  localparam int unsigned FLD_SIZE = 2;
  localparam int unsigned FLD_NEXT = 3;

  // Next-pointer flag carrying the per-descriptor interrupt request
  localparam int unsigned FLAG_IRQ_BIT    = 2;
  // Descriptors sit on 16-byte boundaries
  localparam int unsigned DESC_ALIGN_BITS = 4;
endpackage

// File: rtl/ring_dma_rst_sync.sv
module ring_dma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ring_dma_size_norm.sv
module ring_dma_size_norm #(
  parameter int unsigned SIZE_W    = 32,
  parameter int unsigned MAX_BYTES = 65536,
  parameter int unsigned CNT_W     = $clog2(MAX_BYTES) + 1
) (
  input  logic [SIZE_W-1:0] raw_bytes,
  output logic [CNT_W-1:0]  eff_bytes,
  output logic              eff_zero
);
  localparam logic [SIZE_W-1:0] CAP = SIZE_W'(MAX_BYTES);

  logic [SIZE_W-1:0] capped;

  always_comb begin
    capped      = (raw_bytes > CAP) ? CAP : raw_bytes;
    capped[1:0] = 2'b00;
  end

  assign eff_bytes = capped[CNT_W-1:0];
  assign eff_zero  = (capped == '0);
endmodule

// File: rtl/ring_dma_ctl.sv
module ring_dma_ctl
  import ring_dma_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ctl_wr,
  input  logic                       ctl_enable,
  input  logic                       ctl_start,
  input  logic                       ctl_irq_clr,
  input  logic [DESC_ALIGN_BITS-1:0] ptr_low,
  input  logic                       abort,
  input  logic                       idle,
  input  logic                       tc_irq,
  output logic                       start_req,
  output logic                       stop_req,
  output logic                       irq
);
  logic irq_q, irq_d;
  logic abort_q, abort_d;
  logic irq_en, abort_en;

  assign start_req = ctl_wr && ctl_enable && ctl_start && ctl_irq_clr &&
                     idle && (ptr_low == '0);
  assign stop_req  = abort_q || abort;
  assign irq       = irq_q;

  always_comb begin
    irq_en = tc_irq || (ctl_wr && ctl_irq_clr);
    irq_d  = tc_irq;  // completion has priority over a clear
    abort_en = idle ? abort_q : abort;
    abort_d  = !idle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      if (irq_en)   irq_q   <= irq_d;
      if (abort_en) abort_q <= abort_d;
    end
  end

  // R9: the interrupt flag holds until a clear arrives
  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !(ctl_wr && ctl_irq_clr) |=> irq_q);

  // R10: a clear without a simultaneous completion drops the flag
  assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_irq_clr && !tc_irq |=> !irq_q);

  // R9: a completion always leaves the flag set
  assert_irq_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tc_irq |=> irq_q);
endmodule

// File: rtl/ring_dma_seq.sv
module ring_dma_seq
  import ring_dma_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned DW        = 32,
  parameter int unsigned MAX_BYTES = 65536,
  parameter int unsigned CNT_W     = $clog2(MAX_BYTES) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic [AW-1:0] start_ptr,
  input  logic          stop_req,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  input  logic          src_ready,
  input  logic [DW-1:0] src_data,
  output logic          src_pop,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] cur_dst,
  output logic          idle,
  output logic          tc_irq
);
  localparam int unsigned WORD_BYTES = DW / 8;
  localparam logic [AW-1:0]    ADDR_STEP = AW'(WORD_BYTES);
  localparam logic [CNT_W-1:0] CNT_STEP  = CNT_W'(WORD_BYTES);

  dma_state_t     state_q, state_d;
  logic [1:0]     idx_q, idx_d;
  logic [AW-1:0]  base_q, base_d;
  logic [AW-1:0]  dst_q, dst_d;
  logic [AW-1:0]  srcf_q, srcf_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic [AW-1:0]  next_q, next_d;
  logic           irqf_q, irqf_d;
  logic [DW-1:0]  word_q, word_d;

  logic             ctrl_en, base_en, dst_en, srcf_en, left_en, next_en, word_en;
  logic [CNT_W-1:0] norm_bytes;
  logic             norm_zero;
  logic             fetch_done, word_done, last_word;

  ring_dma_size_norm #(
    .SIZE_W   (DW),
    .MAX_BYTES(MAX_BYTES),
    .CNT_W    (CNT_W)
  ) u_norm (
    .raw_bytes(mem_rdata),
    .eff_bytes(norm_bytes),
    .eff_zero (norm_zero)
  );

  assign fetch_done = (state_q == ST_FETCH) && mem_ack;
  assign word_done  = (state_q == ST_WRITE) && mem_ack;
  assign last_word  = (left_q == CNT_STEP);

  // Bus and source strobes
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = dst_q;
    mem_wdata = word_q;
    src_pop   = 1'b0;
    unique case (state_q)
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = base_q + AW'({idx_q, 2'b00});
      end
      ST_WAIT_SRC: src_pop = src_ready && !stop_req;
      ST_WRITE: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
      end
      default: ;
    endcase
  end

  // Next-state logic
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    tc_irq  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_req) begin
        idx_d   = 2'd0;
        state_d = ST_FETCH;
      end
      ST_FETCH: if (mem_ack) begin
        if (idx_q == 2'(FLD_NEXT)) begin
          // left_q already holds the normalised count
          state_d = (stop_req || left_q == '0) ? ST_IDLE : ST_WAIT_SRC;
        end else begin
          idx_d   = idx_q + 2'd1;
          state_d = stop_req ? ST_IDLE : ST_FETCH;
        end
      end
      ST_WAIT_SRC: begin
        if (stop_req)       state_d = ST_IDLE;
        else if (src_ready) state_d = ST_WRITE;
      end
      ST_WRITE: if (mem_ack) begin
        if (last_word) begin
          tc_irq  = irqf_q;
          idx_d   = 2'd0;
          state_d = stop_req ? ST_IDLE : ST_FETCH;
        end else begin
          state_d = stop_req ? ST_IDLE : ST_WAIT_SRC;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Datapath next values and clock enables
  always_comb begin
    ctrl_en = 1'b1;
    base_en = (state_q == ST_IDLE && start_req) || (word_done && last_word);
    base_d  = (state_q == ST_IDLE) ? start_ptr : next_q;
    dst_en  = (fetch_done && idx_q == 2'(FLD_DST)) || word_done;
    dst_d   = (state_q == ST_FETCH) ? AW'(mem_rdata) : dst_q + ADDR_STEP;
    srcf_en = fetch_done && idx_q == 2'(FLD_SRC);
    srcf_d  = AW'(mem_rdata);
    left_en = (fetch_done && idx_q == 2'(FLD_SIZE)) || word_done;
    left_d  = (state_q == ST_FETCH) ? norm_bytes : left_q - CNT_STEP;
    next_en = fetch_done && idx_q == 2'(FLD_NEXT);
    next_d  = {mem_rdata[AW-1:DESC_ALIGN_BITS], DESC_ALIGN_BITS'(0)};
    irqf_d  = mem_rdata[FLAG_IRQ_BIT];
    word_en = src_pop;
    word_d  = src_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= 2'd0;
      base_q  <= '0;
      dst_q   <= '0;
      srcf_q  <= '0;
      left_q  <= '0;
      next_q  <= '0;
      irqf_q  <= 1'b0;
      word_q  <= '0;
    end else begin
      if (ctrl_en) begin
        state_q <= state_d;
        idx_q   <= idx_d;
      end
      if (base_en) base_q <= base_d;
      if (dst_en)  dst_q  <= dst_d;
      if (srcf_en) srcf_q <= srcf_d;
      if (left_en) left_q <= left_d;
      if (next_en) begin
        next_q <= next_d;
        irqf_q <= irqf_d;
      end
      if (word_en) word_q <= word_d;
    end
  end

  assign src_addr = srcf_q;
  assign cur_dst  = dst_q;
  assign idle     = (state_q == ST_IDLE);

  // R7: a request is held steady until acknowledged
  assert_bus_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) &&
                            $stable(mem_wdata));

  // R5: demand mode, no pop without data
  assert_pop_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    src_pop |-> src_ready);

  // R5: destination advances one word per completed write
  assert_dst_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack |=> cur_dst == $past(cur_dst) + ADDR_STEP);

  // R6: source address is fixed while words are moving
  assert_src_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    src_pop |=> $stable(src_addr));

  // R11: stop request while waiting for data ends the run
  assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req && state_q == ST_WAIT_SRC |=> state_q == ST_IDLE && !mem_req);
endmodule

// File: rtl/ring_dma_engine.sv
module ring_dma_engine
  import ring_dma_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned DW        = 32,
  parameter int unsigned MAX_BYTES = 65536
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic          ctl_enable,
  input  logic          ctl_start,
  input  logic          ctl_irq_clr,
  input  logic [AW-1:0] ctl_ptr,
  input  logic          abort,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  input  logic          src_ready,
  input  logic [DW-1:0] src_data,
  output logic          src_pop,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] cur_dst,
  output logic          busy,
  output logic          irq
);
  localparam int unsigned CNT_W = $clog2(MAX_BYTES) + 1;

  logic rst_sync_n;
  logic start_req, stop_req, idle, tc_irq;

  ring_dma_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  ring_dma_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ctl_wr     (ctl_wr),
    .ctl_enable (ctl_enable),
    .ctl_start  (ctl_start),
    .ctl_irq_clr(ctl_irq_clr),
    .ptr_low    (ctl_ptr[DESC_ALIGN_BITS-1:0]),
    .abort      (abort),
    .idle       (idle),
    .tc_irq     (tc_irq),
    .start_req  (start_req),
    .stop_req   (stop_req),
    .irq        (irq)
  );

  ring_dma_seq #(
    .AW       (AW),
    .DW       (DW),
    .MAX_BYTES(MAX_BYTES),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start_req(start_req),
    .start_ptr(ctl_ptr),
    .stop_req (stop_req),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata),
    .mem_ack  (mem_ack),
    .src_ready(src_ready),
    .src_data (src_data),
    .src_pop  (src_pop),
    .src_addr (src_addr),
    .cur_dst  (cur_dst),
    .idle     (idle),
    .tc_irq   (tc_irq)
  );

  assign busy = !idle;

  // R1/R2: the engine only leaves idle on a complete, aligned start write
  assert_start_gate_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(busy) |-> $past(ctl_wr && ctl_enable && ctl_start && ctl_irq_clr &&
                          ctl_ptr[DESC_ALIGN_BITS-1:0] == '0));
endmodule

// File: tb/tb_ring_dma_engine.sv
module tb_ring_dma_engine;
  typedef struct {
    bit          we;
    logic [31:0] addr;
    logic [31:0] data;
    logic [31:0] src;
    bit          tc;
  } txn_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_wr, ctl_enable, ctl_start, ctl_irq_clr;
  logic [31:0] ctl_ptr;
  logic        abort;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata;
  logic        mem_ack;
  logic        src_ready;
  logic [31:0] src_data;
  logic        src_pop;
  logic [31:0] src_addr, cur_dst;
  logic        busy, irq;

  int   n_cmp = 0;
  int   n_bad = 0;
  int   cyc = 0;
  int   acked = 0;
  bit   chk_on = 1'b0;
  bit   slow = 1'b0;
  bit   gappy = 1'b0;
  bit   irq_exp = 1'b0;
  bit   done = 1'b0;
  logic [31:0] fifo_ctr = 32'h1000_0000;
  logic [31:0] mem [logic [31:0]];
  txn_t exp_q[$];

  always #2 clk = ~clk;  // 250 MHz

  ring_dma_engine dut (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(ctl_wr), .ctl_enable(ctl_enable), .ctl_start(ctl_start),
    .ctl_irq_clr(ctl_irq_clr), .ctl_ptr(ctl_ptr), .abort(abort),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .src_ready(src_ready), .src_data(src_data), .src_pop(src_pop),
    .src_addr(src_addr), .cur_dst(cur_dst), .busy(busy), .irq(irq)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Memory responder and FIFO source
  assign src_data = fifo_ctr;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= 32'h0;
      src_ready <= 1'b0;
    end else begin
      if (mem_req && !mem_ack && (!slow || (cyc % 3) == 1)) begin
        mem_ack   <= 1'b1;
        mem_rdata <= rd(mem_addr);
      end else begin
        mem_ack <= 1'b0;
      end
      src_ready <= gappy ? ((cyc % 5) != 2) : 1'b1;
      if (src_pop) fifo_ctr <= fifo_ctr + 32'd1;
    end
  end

  // Reference comparison, every cycle between edges
  always @(negedge clk) begin
    bit   set_now;
    txn_t t;
    if (chk_on) begin
      check(irq === irq_exp, "R9/R10 irq", {31'b0, irq}, {31'b0, irq_exp});
      if (src_pop && !src_ready) check(1'b0, "R5 pop without ready", 32'h1, 32'h0);
      set_now = 1'b0;
      if (mem_req && mem_ack) begin
        acked++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R3/R11 unexpected transaction", mem_addr, 32'hFFFF_FFFF);
        end else begin
          t = exp_q.pop_front();
          check(mem_we === t.we, "R3 read/write order", {31'b0, mem_we}, {31'b0, t.we});
          check(mem_addr === t.addr, "R3/R8 address", mem_addr, t.addr);
          if (t.we) begin
            check(mem_wdata === t.data, "R5 write data", mem_wdata, t.data);
            check(cur_dst === t.addr, "R5 cur_dst", cur_dst, t.addr);
            check(src_addr === t.src, "R6 src_addr", src_addr, t.src);
            set_now = t.tc;
          end
        end
        if (mem_we) mem[mem_addr] = mem_wdata;
      end
      if (set_now) irq_exp = 1'b1;
      else if (ctl_wr && ctl_irq_clr) irq_exp = 1'b0;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <190000 cycles", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // Expected transaction stream built from the descriptors in memory
  task automatic build(input logic [31:0] ptr, input int limit);
    int          n = 0;
    int          k = 0;
    logic [31:0] p = ptr;
    logic [31:0] d, s, z, nx, base;
    txn_t        t;
    base = fifo_ctr;
    while (n < limit) begin
      d = rd(p); s = rd(p + 4); z = rd(p + 8); nx = rd(p + 12);
      for (int i = 0; i < 4; i++) begin
        t.we = 1'b0; t.addr = p + 32'(4 * i); t.data = 32'h0; t.src = 32'h0; t.tc = 1'b0;
        exp_q.push_back(t);
        n++;
      end
      z = (z > 32'd65536) ? 32'd65536 : z;
      z[1:0] = 2'b00;
      if (z == 0) break;
      for (int w = 0; w < int'(z / 4) && n < limit; w++) begin
        t.we = 1'b1; t.addr = d + 32'(4 * w); t.data = base + 32'(k);
        t.src = s; t.tc = (w == int'(z / 4) - 1) && nx[2];
        exp_q.push_back(t);
        k++; n++;
      end
      p = nx & ~32'hF;
    end
  endtask

  task automatic ctl_write(input bit en, input bit go, input bit clr,
                           input logic [31:0] ptr);
    @(posedge clk); #1;
    ctl_wr = 1'b1; ctl_enable = en; ctl_start = go; ctl_irq_clr = clr; ctl_ptr = ptr;
    @(posedge clk); #1;
    ctl_wr = 1'b0; ctl_enable = 1'b0; ctl_start = 1'b0; ctl_irq_clr = 1'b0;
  endtask

  task automatic do_abort(output int at);
    @(posedge clk); #1;
    abort = 1'b1; at = acked;
    @(posedge clk); #1;
    abort = 1'b0;
  endtask

  task automatic wait_acked(input int target);
    while (acked < target) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic check_quiet(input string req);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!mem_req && !busy, req, {30'b0, mem_req, busy}, 32'h0);
    end
  endtask

  initial begin
    int at, a0;
    rst_n = 1'b0; ctl_wr = 1'b0; ctl_enable = 1'b0; ctl_start = 1'b0;
    ctl_irq_clr = 1'b0; ctl_ptr = 32'h0; abort = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(busy === 1'b0, "R1 reset busy", {31'b0, busy}, 32'h0);
    check(irq === 1'b0, "R1 reset irq", {31'b0, irq}, 32'h0);
    check(mem_req === 1'b0 && src_pop === 1'b0, "R1 reset strobes",
          {30'b0, mem_req, src_pop}, 32'h0);
    chk_on = 1'b1;

    // Ring: desc A at 0x00 -> desc B at 0x10 -> back to A (flags set in low bits)
    mem[32'h00] = 32'h0000_0400; mem[32'h04] = 32'h0000_ABC0;
    mem[32'h08] = 32'd10;        mem[32'h0C] = 32'h0000_001D; // irq flag + 0x1 + 0x8
    mem[32'h10] = 32'h0000_0500; mem[32'h14] = 32'h0000_1234;
    mem[32'h18] = 32'd7;         mem[32'h1C] = 32'h0000_0009; // no irq flag
    // Zero-size descriptor
    mem[32'h40] = 32'h0000_0600; mem[32'h44] = 32'h0; mem[32'h48] = 32'd3; mem[32'h4C] = 32'h40;
    // Oversized descriptor pointing to itself
    mem[32'h80] = 32'h0001_0000; mem[32'h84] = 32'h55; mem[32'h88] = 32'h0001_0007;
    mem[32'h8C] = 32'h0000_0084;

    // R2: misaligned pointer, then incomplete control bits
    ctl_write(1'b1, 1'b1, 1'b1, 32'h0000_0104);
    check_quiet("R2 misaligned start");
    ctl_write(1'b1, 1'b1, 1'b0, 32'h0);
    check_quiet("R2 start without clear bit");
    check(acked == 0, "R2 no bus traffic", 32'(acked), 32'h0);

    // Ring run with late acks and gaps in FIFO data (R3 R5 R6 R7 R8 R9)
    slow = 1'b1; gappy = 1'b1;
    build(32'h0, 60);
    ctl_write(1'b1, 1'b1, 1'b1, 32'h0);
    @(negedge clk);
    check(busy === 1'b1, "R1 busy after start", {31'b0, busy}, 32'h1);
    wait_acked(8);
    // R10: clear-only write mid-run keeps the engine busy
    ctl_write(1'b0, 1'b0, 1'b1, 32'h0);
    @(negedge clk);
    check(busy === 1'b1, "R10 busy after clear", {31'b0, busy}, 32'h1);
    check(irq === 1'b0, "R10 irq cleared", {31'b0, irq}, 32'h0);
    wait_acked(30);  // into the third lap (R8)
    check(mem[32'h404] === rd(32'h404) && rd(32'h500) != 32'h0, "R5 ring data landed",
          rd(32'h500), 32'h1);
    do_abort(at);
    wait_idle();
    check(acked - at <= 1, "R11 at most one transaction after abort",
          32'(acked - at), 32'h1);
    check_quiet("R11 quiet after abort");
    exp_q.delete();
    ctl_write(1'b0, 1'b0, 1'b1, 32'h0);

    // R4: count of 3 rounds to zero, no writes
    slow = 1'b0; gappy = 1'b0;
    a0 = acked;
    build(32'h40, 4);
    ctl_write(1'b1, 1'b1, 1'b1, 32'h40);
    wait_idle();
    check(acked - a0 == 4, "R4 zero-size fetch only", 32'(acked - a0), 32'h4);
    check(exp_q.size() == 0, "R4 expected stream consumed", 32'(exp_q.size()), 32'h0);
    check_quiet("R4 idle after zero size");

    // R4/R9: oversized count capped at 16384 words, then refetch and irq
    a0 = acked;
    build(32'h80, 4 + 16384 + 4 + 8);
    ctl_write(1'b1, 1'b1, 1'b1, 32'h80);
    wait_acked(a0 + 4 + 16384 + 2);
    check(irq === 1'b1, "R9 irq after capped descriptor", {31'b0, irq}, 32'h1);
    do_abort(at);
    wait_idle();
    check(acked - at <= 1, "R11 abort during fetch", 32'(acked - at), 32'h1);
    check(rd(32'h0001_0000 + 32'd65532) != 32'h0, "R4 last capped word written",
          rd(32'h0001_0000 + 32'd65532), 32'h1);
    check(!mem.exists(32'h0001_0000 + 32'd65536), "R4 no word past cap",
          32'h0, 32'h0);

    chk_on = 1'b0;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule